// File: doc/BRIEF.md
# SIMD Processing Element Array

A lockstep array of integer processing elements. One sequencer latches a single instruction and hands it to every element at once. Each element has a 64-bit bit-parallel datapath, four 64-bit registers (accumulator A, operand buffer B, scratchpad S, routing register R) and its own private word memory. R is the only register that can move data between elements. A route instruction rotates the R values around the ring by a signed distance.

Compares do not branch. Each element compares its accumulator with a selected register and writes the result into its own mode bit. Elements whose mode bit is 0 skip every gated instruction until a later compare or a set-mode instruction changes the bit. Every instruction takes the same number of cycles whatever the operand values, so the elements never fall out of step.

A host drives the instruction fields together with a start strobe and waits for the done pulse. It can then read any register, or the mode bit, of any element through a combinational readback port. The element count, data width and memory depth are parameters. The memory depth defaults to 256 words so that the default elaboration stays small; the datapath supports any power-of-two depth, such as 2048.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, every register of every element reads 0, every mode bit reads 1 and done_o is 0.
- R2: Register selects are A=0, B=1, S=2, R=3. LDI (op 1) writes data_i into register dst. LDX (op 2) writes data_i plus the element index into dst. MOV (op 3) copies register src into dst.
- R3: ADD (op 4) and SUB (op 5) replace A with A+src or A-src, wrapping modulo 2^64.
- R4: AND (op 6), OR (op 7) and XOR (op 8) replace A with the bitwise result of A and src.
- R5: CEQ (op 11) sets each element's mode bit to (A == src). CLT (op 12) sets it to (A < src), unsigned. Both run on every element regardless of mode and change no register.
- R6: Ops 1 to 10 are gated. An element whose mode bit is 0 leaves A, B, S, R and its memory unchanged for a gated op.
- R7: SETM (op 13) sets every mode bit to 1.
- R8: STORE (op 10) writes A to local memory at addr_i. LOAD (op 9) writes the word at addr_i into A. Both are gated.
- R9: ROUTE (op 14) writes the R of element i into the R of element (i+k) mod N for every element, where k is the two's-complement shift_i. It ignores mode bits and changes no other register.
- R10: A start accepted at a clock edge gives a one-cycle done_o in the second cycle after that edge's cycle. Results are visible on readback while done_o is high.
- R11: A start that arrives while an instruction is in progress is ignored and produces no further done pulse. Op 0 and op 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue strobe, accepted when idle |
| op_i | input | 4 | Opcode |
| dst_i | input | 2 | Destination register select |
| src_i | input | 2 | Source register select |
| addr_i | input | $clog2(MEM_DEPTH) | Local memory address |
| shift_i | input | $clog2(N_PE)+1 | Signed route distance |
| data_i | input | DW | Broadcast data word |
| done_o | output | 1 | One-cycle completion pulse |
| rd_pe_i | input | $clog2(N_PE) | Readback element select |
| rd_reg_i | input | 2 | Readback register select |
| rd_data_o | output | DW | Selected register value |
| rd_mode_o | output | 1 | Mode bit of the selected element |

## Verification
Every broadcast instruction reaches all elements identically. The hardest thing to produce from the ports is therefore a state in which the elements differ, with some mode bits 0 and others 1. The stimulus first uses LDX to give each element an index-dependent accumulator, then runs CLT or CEQ against a broadcast threshold to split the mode bits. Gated arithmetic, stores and routes are then issued under that split mask. Routing is swept over every signed distance from -N to N-1, so that both the negative and the wrap-around index paths are exercised.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDI   = 4'd1,
    OP_LDX   = 4'd2,
    OP_MOV   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_LOAD  = 4'd9,
    OP_STORE = 4'd10,
    OP_CEQ   = 4'd11,
    OP_CLT   = 4'd12,
    OP_SETM  = 4'd13,
    OP_ROUTE = 4'd14
  } op_e;

  localparam logic [1:0] REG_A = 2'd0;
  localparam logic [1:0] REG_R = 2'd3;

  function automatic logic is_gated(op_e op);
    return (op inside {OP_LDI, OP_LDX, OP_MOV, OP_ADD, OP_SUB, OP_AND,
                       OP_OR, OP_XOR, OP_LOAD, OP_STORE});
  endfunction
endpackage

// File: rtl/simd_seq.sv
module simd_seq #(
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          exec_o,
  output logic          done_o
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_DONE} state_e;
  state_e        state_q;
  logic [IW-1:0] instr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      instr_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_EXEC;
          instr_q <= instr_i;
        end
        S_EXEC:  state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign instr_o = instr_q;
  assign exec_o  = (state_q == S_EXEC);
  assign done_o  = (state_q == S_DONE);

  AST_START_TO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i) |=> exec_o); // R10
  AST_EXEC_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> done_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_INSTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(instr_q)); // R11
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW        = 64,
  parameter int MEM_DEPTH = 256,
  parameter int AW        = $clog2(MEM_DEPTH),
  parameter int IDX       = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                exec_i,
  input  op_e                 op_i,
  input  logic [1:0]          dst_i,
  input  logic [1:0]          src_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic [DW-1:0]       route_i,
  output logic [3:0][DW-1:0]  regs_o,
  output logic                mode_o
);
  logic [3:0][DW-1:0] regs_q;
  logic               mode_q;
  logic [DW-1:0]      mem_q [MEM_DEPTH];
  logic [DW-1:0]      a_v, src_v, alu_v;
  logic               act;

  assign a_v   = regs_q[REG_A];
  assign src_v = regs_q[src_i];
  assign act   = exec_i && (!is_gated(op_i) || mode_q);

  always_comb begin
    unique case (op_i)
      OP_ADD:  alu_v = a_v + src_v;
      OP_SUB:  alu_v = a_v - src_v;
      OP_AND:  alu_v = a_v & src_v;
      OP_OR:   alu_v = a_v | src_v;
      OP_XOR:  alu_v = a_v ^ src_v;
      default: alu_v = a_v;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
      mode_q <= 1'b1;
    end else if (act) begin
      case (op_i)
        OP_LDI:  regs_q[dst_i] <= data_i;
        OP_LDX:  regs_q[dst_i] <= data_i + DW'(IDX);
        OP_MOV:  regs_q[dst_i] <= src_v;
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: regs_q[REG_A] <= alu_v;
        OP_LOAD: regs_q[REG_A] <= mem_q[addr_i];
        OP_CEQ:  mode_q <= (a_v == src_v);
        OP_CLT:  mode_q <= (a_v < src_v);
        OP_SETM: mode_q <= 1'b1;
        OP_ROUTE: regs_q[REG_R] <= route_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (act && op_i == OP_STORE) mem_q[addr_i] <= a_v;
  end

  assign regs_o = regs_q;
  assign mode_o = mode_q;

  AST_GATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !mode_q && is_gated(op_i)) |=> $stable(regs_q)); // R6
  AST_CMP_NO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op_i == OP_CEQ || op_i == OP_CLT)) |=> $stable(regs_q)); // R5
  AST_SETM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_SETM) |=> mode_q); // R7
  AST_ROUTE_ONLY_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_ROUTE) |=> ($stable(regs_q[2:0]) && $stable(mode_q))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(regs_q) && $stable(mode_q))); // R11
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int  N_PE      = 8,
  parameter int  DW        = 64,
  parameter int  MEM_DEPTH = 256,
  localparam int AW        = $clog2(MEM_DEPTH),
  localparam int SW        = $clog2(N_PE) + 1,
  localparam int PW        = $clog2(N_PE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    dst_i,
  input  logic [1:0]    src_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] shift_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  input  logic [PW-1:0] rd_pe_i,
  input  logic [1:0]    rd_reg_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_mode_o
);
  localparam int IW = 4 + 2 + 2 + AW + SW + DW;

  logic [IW-1:0] instr_d, instr_q;
  logic          exec;
  logic [3:0]    op_q;
  logic [1:0]    dst_q, src_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] shift_q;
  logic [DW-1:0] data_q;

  logic [N_PE-1:0][3:0][DW-1:0] regs_all;
  logic [N_PE-1:0]              mode_all;
  logic [N_PE-1:0][DW-1:0]      r_all, r_in;

  assign instr_d = {op_i, dst_i, src_i, addr_i, shift_i, data_i};
  assign {op_q, dst_q, src_q, addr_q, shift_q, data_q} = instr_q;

  simd_seq #(.IW(IW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .instr_i (instr_d),
    .instr_o (instr_q),
    .exec_o  (exec),
    .done_o  (done_o)
  );

  // element i receives from element (i - k) mod N
  always_comb begin
    for (int i = 0; i < N_PE; i++) begin
      int j;
      j = ((i - int'($signed(shift_q))) % N_PE + N_PE) % N_PE;
      r_in[i] = r_all[j];
    end
  end

  for (genvar g = 0; g < N_PE; g++) begin : g_pe
    simd_pe #(.DW(DW), .MEM_DEPTH(MEM_DEPTH), .AW(AW), .IDX(g)) u_pe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .exec_i  (exec),
      .op_i    (op_e'(op_q)),
      .dst_i   (dst_q),
      .src_i   (src_q),
      .addr_i  (addr_q),
      .data_i  (data_q),
      .route_i (r_in[g]),
      .regs_o  (regs_all[g]),
      .mode_o  (mode_all[g])
    );
    assign r_all[g] = regs_all[g][REG_R];
  end

  assign rd_data_o = regs_all[rd_pe_i][rd_reg_i];
  assign rd_mode_o = mode_all[rd_pe_i];

  AST_ROUTE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op_e'(op_q) == OP_ROUTE) |=>
      ($countones(mode_all) == $countones($past(mode_all)))); // R9
endmodule

// File: tb/test_simd_pe_array.sv
`timescale 1ns/1ps
module test_simd_pe_array;
  localparam int N = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] dst = '0, src = '0;
  logic [7:0] addr = '0;
  logic [3:0] shift = '0;
  logic [63:0] data = '0;
  logic done;
  logic [2:0] rd_pe = '0;
  logic [1:0] rd_reg = '0;
  logic [63:0] rd_data;
  logic rd_mode;

  int checks = 0;
  int errors = 0;

  logic [63:0] ma [N][4];
  logic        mm [N];
  logic [63:0] mmem [N][DEPTH];

  always #2.5 clk = ~clk;

  simd_pe_array #(.N_PE(N), .DW(64), .MEM_DEPTH(DEPTH)) i_simd_pe_array (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .dst_i(dst),
    .src_i(src), .addr_i(addr), .shift_i(shift), .data_i(data), .done_o(done),
    .rd_pe_i(rd_pe), .rd_reg_i(rd_reg), .rd_data_o(rd_data), .rd_mode_o(rd_mode)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic verify_all(string tag);
    for (int p = 0; p < N; p++) begin
      rd_pe = 3'(p);
      for (int r = 0; r < 4; r++) begin
        rd_reg = 2'(r);
        #0.2;
        chk(tag, rd_data, ma[p][r]);
      end
      #0.2;
      chk({tag, " mode"}, {63'd0, rd_mode}, {63'd0, mm[p]});
    end
  endtask

  task automatic model(int o, int d, int s, int a, int k, logic [63:0] v);
    logic [63:0] na [N][4];
    logic        nm [N];
    for (int i = 0; i < N; i++) begin
      for (int r = 0; r < 4; r++) na[i][r] = ma[i][r];
      nm[i] = mm[i];
    end
    for (int i = 0; i < N; i++) begin
      logic g;
      g = (o >= 1 && o <= 10) ? mm[i] : 1'b1;
      if (g) begin
        case (o)
          1:  na[i][d] = v;
          2:  na[i][d] = v + 64'(i);
          3:  na[i][d] = ma[i][s];
          4:  na[i][0] = ma[i][0] + ma[i][s];
          5:  na[i][0] = ma[i][0] - ma[i][s];
          6:  na[i][0] = ma[i][0] & ma[i][s];
          7:  na[i][0] = ma[i][0] | ma[i][s];
          8:  na[i][0] = ma[i][0] ^ ma[i][s];
          9:  na[i][0] = mmem[i][a];
          10: mmem[i][a] = ma[i][0];
          11: nm[i] = (ma[i][0] == ma[i][s]);
          12: nm[i] = (ma[i][0] < ma[i][s]);
          13: nm[i] = 1'b1;
          14: na[((i + k) % N + N) % N][3] = ma[i][3];
          default: ;
        endcase
      end
    end
    for (int i = 0; i < N; i++) begin
      for (int r = 0; r < 4; r++) ma[i][r] = na[i][r];
      mm[i] = nm[i];
    end
  endtask

  task automatic issue(string tag, int o, int d, int s, int a, int k,
                       logic [63:0] v, bit poke);
    @(negedge clk);
    op = 4'(o); dst = 2'(d); src = 2'(s); addr = 8'(a); shift = 4'(k); data = v;
    start = 1'b1;
    @(negedge clk);
    chk({tag, " R10 done early"}, {63'd0, done}, 64'd0);
    if (poke) begin
      op = 4'd1; dst = 2'd0; data = 64'hDEAD_BEEF_0BAD_F00D;  // must be ignored, R11
    end else start = 1'b0;
    model(o, d, s, a, k, v);
    @(negedge clk);
    chk({tag, " R10 done"}, {63'd0, done}, 64'd1);
    start = 1'b0;
    verify_all(tag);
    @(negedge clk);
    chk({tag, " R10 done width"}, {63'd0, done}, 64'd0);
    @(negedge clk);
    chk({tag, " R11 no extra done"}, {63'd0, done}, 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    logic [63:0] ds [3];
    ds[0] = 64'h0123_4567_89AB_CDEF;
    ds[1] = 64'hFFFF_FFFF_FFFF_FFF0;
    ds[2] = 64'h8000_0000_0000_0001;
    for (int i = 0; i < N; i++) begin
      for (int r = 0; r < 4; r++) ma[i][r] = '0;
      mm[i] = 1'b1;
    end
    #12;
    chk("R1 done at reset", {63'd0, done}, 64'd0);
    verify_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    for (int p = 0; p < 3; p++) begin
      issue("R2 ldx A", 2, 0, 0, 0, 0, ds[p], 0);
      issue("R2 ldx B", 2, 1, 0, 0, 0, ds[(p + 1) % 3], 0);
      issue("R2 ldi S", 1, 2, 0, 0, 0, ~ds[p], 0);
      issue("R2 ldx R", 2, 3, 0, 0, 0, ds[p] << 3, 0);
      for (int o = 4; o <= 8; o++)
        for (int s = 0; s < 4; s++)
          issue((o < 6) ? "R3 addsub" : "R4 logic", o, 0, s, 0, 0, '0, 0);
      issue("R2 mov B<-A", 3, 1, 0, 0, 0, '0, 0);
      issue("R2 mov S<-R", 3, 2, 3, 0, 0, '0, 0);
    end
    issue("R11 nop", 0, 0, 0, 0, 0, 64'h55, 0);
    issue("R11 op15", 15, 0, 0, 0, 0, 64'h55, 0);

    // split mask: A = i, B = 4 -> mode = i < 4
    issue("R2 ldx A0", 2, 0, 0, 0, 0, 64'd0, 0);
    issue("R2 ldi B4", 1, 1, 0, 0, 0, 64'd4, 0);
    issue("R5 clt", 12, 0, 1, 0, 0, '0, 0);
    issue("R6 add gated", 4, 0, 1, 0, 0, '0, 0);
    issue("R6 ldi gated", 1, 2, 0, 0, 0, 64'hAAAA, 0);
    issue("R6 ldx gated", 2, 3, 0, 0, 0, 64'h100, 0);
    issue("R6 mov gated", 3, 1, 2, 0, 0, '0, 0);
    issue("R7 setm", 13, 0, 0, 0, 0, '0, 0);

    // memory
    issue("R8 ldx A", 2, 0, 0, 0, 0, 64'd1000, 0);
    issue("R8 store 5", 10, 0, 0, 5, 0, '0, 0);
    issue("R8 store 255", 10, 0, 0, 255, 0, '0, 0);
    issue("R2 ldx A0", 2, 0, 0, 0, 0, 64'd0, 0);
    issue("R2 ldi B3", 1, 1, 0, 0, 0, 64'd3, 0);
    issue("R5 ceq", 11, 0, 1, 0, 0, '0, 0);
    issue("R6 ldx A gated", 2, 0, 0, 0, 0, 64'd2000, 0);
    issue("R6 store gated", 10, 0, 0, 5, 0, '0, 0);
    issue("R7 setm", 13, 0, 0, 0, 0, '0, 0);
    issue("R8 load 5", 9, 0, 0, 5, 0, '0, 0);
    issue("R8 ldi A", 1, 0, 0, 0, 0, 64'd7, 0);
    issue("R8 load 255", 9, 0, 0, 255, 0, '0, 0);

    // route sweep
    issue("R2 ldx R", 2, 3, 0, 0, 0, 64'h10, 0);
    for (int k = -8; k < 8; k++) issue("R9 route", 14, 0, 0, 0, k, '0, 0);
    issue("R2 ldx A0", 2, 0, 0, 0, 0, 64'd0, 0);
    issue("R2 ldi B2", 1, 1, 0, 0, 0, 64'd2, 0);
    issue("R5 clt", 12, 0, 1, 0, 0, '0, 0);
    issue("R9 route masked +3", 14, 0, 0, 0, 3, '0, 0);
    issue("R9 route masked -5", 14, 0, 0, 0, -5, '0, 0);
    issue("R7 setm", 13, 0, 0, 0, 0, '0, 0);

    // busy start ignored
    issue("R11 busy start", 1, 0, 0, 0, 0, 64'd77, 1);
    issue("R11 busy start2", 4, 0, 1, 0, 0, '0, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule